// File: doc/BRIEF.md
# Traffic Phase Interval Timer

This block measures how long each of the three lamps of a traffic signal has been lit and tells the light sequencer when each phase has lasted long enough. It holds one counter per lamp. All three run on the fast system clock and advance only on a one-cycle tick that arrives once per second. The green timer counts in two-digit BCD. The red timer counts in plain binary. The amber timer has a fixed length.

The sequencer starts a phase with an active-low clear pulse to that lamp's timer. The timer then counts seconds until its count equals the interval setting. At that point its run flag drops low. The low flag stops the timer, which keeps its final count on its output for the display. The same flag tells the sequencer that the phase is over. The interval settings may change while a phase runs. A timer that never matches stops at 99 and does not wrap.

Top module: `phase_timer_set`

## Requirements
- R1: While `rst` is high, all three counts go to zero on the next clock edge. After reset, each run flag is high unless that timer's count equals its setting.
- R2: A low level on a timer's clear input zeroes that timer's count on the next clock edge. Clear wins over a tick in the same cycle. The other timers are not affected.
- R3: A count changes only on a clock edge where `tick` is high. It advances by exactly one step per tick.
- R4: The green count is two BCD digits, with tens in bits [7:4] and units in bits [3:0]. The units digit runs 0 to 9. The tens digit advances only when the units digit rolls over from 9 to 0.
- R5: The red count is a 7-bit binary value that rises by one on each tick while it runs.
- R6: `grn_run` is low exactly when the green count equals `grn_limit` bit for bit. `grn_limit` uses the same BCD layout as the count. While the flag is low, the green count holds through ticks. A setting of 0x00 gives a low flag right after a clear.
- R7: `red_run` is low exactly when the red count equals `red_limit`. While it is low, the red count holds through ticks.
- R8: The amber count rises to 8 and then holds at 8 through any number of ticks. `yel_run` is low exactly while the count is 8.
- R9: If a timer never reaches its setting, its count holds at 99. This covers a BCD setting with a digit above 9 and a red setting above 99. The count never wraps, and the run flag stays high.
- R10: The run flags follow the current settings in the same cycle. If a setting is raised above a held count, that timer resumes counting on the following ticks.
- R11: A clear applied to a timer that has finished restarts it from zero. It counts again on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle pulse, once per second |
| grn_clr_n | input | 1 | Green timer clear, active low |
| yel_clr_n | input | 1 | Amber timer clear, active low |
| red_clr_n | input | 1 | Red timer clear, active low |
| grn_limit | input | 8 | Green interval, two BCD digits |
| red_limit | input | 7 | Red interval, binary |
| grn_count | output | 8 | Green elapsed seconds, BCD |
| yel_count | output | 4 | Amber elapsed seconds, binary |
| red_count | output | 7 | Red elapsed seconds, binary |
| grn_run | output | 1 | Low when the green phase is complete |
| yel_run | output | 1 | Low when the amber phase is complete |
| red_run | output | 1 | Low when the red phase is complete |

## Verification
A corrupted digit or a missed carry in the green timer appears on `grn_count` at the next tick. A stuck match appears on a run flag at once, and the stop-or-overrun shows in the count one tick later. A clear that loses to a tick leaves a count of one instead of zero, and this is visible one clock after the clear. A missing cap only shows after 99 ticks without a match, so the stimulus runs both timers all the way to the cap and keeps ticking past it.

// File: rtl/tl_phase_pkg.sv
package tl_phase_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_digit_t;
  localparam bcd_digit_t DIGIT_TOP = 4'd9;
endpackage

// File: rtl/tl_bin_counter.sv
module tl_bin_counter #(
  parameter int W   = 7,
  parameter int CAP = 99
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         clr_n,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         run
);
  localparam logic [W-1:0] CAP_V = W'(CAP);

  logic [W-1:0] cnt_q;
  logic         hit;
  logic         at_cap;

  assign hit    = (cnt_q == limit);
  assign at_cap = (cnt_q == CAP_V);

  always_ff @(posedge clk) begin
    if (rst || !clr_n) begin
      cnt_q <= '0;
    end else if (tick && !hit && !at_cap) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count = cnt_q;
  assign run   = !hit;
endmodule

// File: rtl/tl_bcd_counter.sv
module tl_bcd_counter
  import tl_phase_pkg::*;
#(
  parameter int DIGITS = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic                    clr_n,
  input  logic [DIGITS*DIGIT_W-1:0] limit,
  output logic [DIGITS*DIGIT_W-1:0] count,
  output logic                    run
);
  localparam int CW = DIGITS * DIGIT_W;
  localparam logic [CW-1:0] ALL_NINES = {DIGITS{DIGIT_TOP}};

  logic [CW-1:0]     cnt_q;
  logic [DIGITS-1:0] step;
  logic              hit;
  logic              adv;

  assign hit = (cnt_q == limit);
  assign adv = tick && !hit && (cnt_q != ALL_NINES);

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    bcd_digit_t dig;
    assign dig = cnt_q[d*DIGIT_W +: DIGIT_W];

    if (d == 0) begin : g_low
      assign step[d] = adv;
    end else begin : g_high
      assign step[d] = step[d-1] && (cnt_q[(d-1)*DIGIT_W +: DIGIT_W] == DIGIT_TOP);
    end

    always_ff @(posedge clk) begin
      if (rst || !clr_n) begin
        cnt_q[d*DIGIT_W +: DIGIT_W] <= '0;
      end else if (step[d]) begin
        cnt_q[d*DIGIT_W +: DIGIT_W] <= (dig == DIGIT_TOP) ? '0 : dig + 1'b1;
      end
    end
  end

  assign count = cnt_q;
  assign run   = !hit;
endmodule

// File: rtl/phase_timer_set.sv
module phase_timer_set #(
  parameter int GRN_DIGITS = 2,
  parameter int RED_W      = 7,
  parameter int RED_CAP    = 99,
  parameter int YEL_SECS   = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              tick,
  input  logic                              grn_clr_n,
  input  logic                              yel_clr_n,
  input  logic                              red_clr_n,
  input  logic [GRN_DIGITS*4-1:0]           grn_limit,
  input  logic [RED_W-1:0]                  red_limit,
  output logic [GRN_DIGITS*4-1:0]           grn_count,
  output logic [$clog2(YEL_SECS+1)-1:0]     yel_count,
  output logic [RED_W-1:0]                  red_count,
  output logic                              grn_run,
  output logic                              yel_run,
  output logic                              red_run
);
  localparam int YEL_W = $clog2(YEL_SECS + 1);
  localparam logic [YEL_W-1:0] YEL_LIMIT = YEL_W'(YEL_SECS);

  tl_bcd_counter #(.DIGITS(GRN_DIGITS)) u_grn (
    .clk(clk), .rst(rst), .tick(tick), .clr_n(grn_clr_n),
    .limit(grn_limit), .count(grn_count), .run(grn_run)
  );

  tl_bin_counter #(.W(RED_W), .CAP(RED_CAP)) u_red (
    .clk(clk), .rst(rst), .tick(tick), .clr_n(red_clr_n),
    .limit(red_limit), .count(red_count), .run(red_run)
  );

  tl_bin_counter #(.W(YEL_W), .CAP(YEL_SECS)) u_yel (
    .clk(clk), .rst(rst), .tick(tick), .clr_n(yel_clr_n),
    .limit(YEL_LIMIT), .count(yel_count), .run(yel_run)
  );
endmodule

// File: rtl/phase_timer_set_chk.sv
module phase_timer_set_chk #(
  parameter int GRN_DIGITS = 2,
  parameter int RED_W      = 7,
  parameter int RED_CAP    = 99,
  parameter int YEL_SECS   = 8
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          tick,
  input logic                          grn_clr_n,
  input logic                          yel_clr_n,
  input logic                          red_clr_n,
  input logic [GRN_DIGITS*4-1:0]       grn_count,
  input logic [$clog2(YEL_SECS+1)-1:0] yel_count,
  input logic [RED_W-1:0]              red_count,
  input logic                          grn_run,
  input logic                          red_run
);
  localparam int YEL_W = $clog2(YEL_SECS + 1);
  localparam logic [RED_W-1:0] RED_CAP_V = RED_W'(RED_CAP);
  localparam logic [YEL_W-1:0] YEL_TOP_V = YEL_W'(YEL_SECS);

  AST_GRN_CLR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    !grn_clr_n |=> grn_count == '0); // R2
  AST_RED_CLR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    !red_clr_n |=> red_count == '0); // R2
  AST_YEL_CLR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    !yel_clr_n |=> yel_count == '0); // R2
  AST_GRN_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (grn_clr_n && !tick) |=> $stable(grn_count)); // R3
  AST_RED_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (red_clr_n && !tick) |=> $stable(red_count)); // R3
  AST_RED_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (red_clr_n && tick && red_run && red_count != RED_CAP_V)
      |=> red_count == $past(red_count) + 1'b1); // R5
  AST_GRN_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (grn_clr_n && !grn_run) |=> $stable(grn_count)); // R6
  AST_RED_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (red_clr_n && !red_run) |=> $stable(red_count)); // R7
  AST_YEL_CEILING: assert property (@(posedge clk) disable iff (rst)
    yel_count <= YEL_TOP_V); // R8
  AST_RED_CEILING: assert property (@(posedge clk) disable iff (rst)
    red_count <= RED_CAP_V); // R9

  for (genvar d = 0; d < GRN_DIGITS; d++) begin : g_dig_chk
    AST_GRN_DIGIT_DECIMAL: assert property (@(posedge clk) disable iff (rst)
      grn_count[d*4 +: 4] <= 4'd9); // R4
  end
endmodule

bind phase_timer_set phase_timer_set_chk #(
  .GRN_DIGITS(GRN_DIGITS), .RED_W(RED_W), .RED_CAP(RED_CAP), .YEL_SECS(YEL_SECS)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick),
  .grn_clr_n(grn_clr_n), .yel_clr_n(yel_clr_n), .red_clr_n(red_clr_n),
  .grn_count(grn_count), .yel_count(yel_count), .red_count(red_count),
  .grn_run(grn_run), .red_run(red_run)
);

// File: tb/phase_timer_set_bench.sv
module phase_timer_set_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       grn_clr_n = 1'b1;
  logic       yel_clr_n = 1'b1;
  logic       red_clr_n = 1'b1;
  logic [7:0] grn_limit = 8'h15;
  logic [6:0] red_limit = 7'd20;
  logic [7:0] grn_count;
  logic [3:0] yel_count;
  logic [6:0] red_count;
  logic       grn_run, yel_run, red_run;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  phase_timer_set u_phase_timer_set (
    .clk(clk), .rst(rst), .tick(tick),
    .grn_clr_n(grn_clr_n), .yel_clr_n(yel_clr_n), .red_clr_n(red_clr_n),
    .grn_limit(grn_limit), .red_limit(red_limit),
    .grn_count(grn_count), .yel_count(yel_count), .red_count(red_count),
    .grn_run(grn_run), .yel_run(yel_run), .red_run(red_run)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic clear_all();
    @(negedge clk);
    grn_clr_n = 1'b0; yel_clr_n = 1'b0; red_clr_n = 1'b0;
    @(negedge clk);
    grn_clr_n = 1'b1; yel_clr_n = 1'b1; red_clr_n = 1'b1;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", "grn_count", int'(grn_count), 0);
    check("R1", "red_count", int'(red_count), 0);
    check("R1", "yel_count", int'(yel_count), 0);
    check("R1", "run flags", int'({grn_run, yel_run, red_run}), 7);
  endtask

  task automatic t_green_red_yellow();
    clear_all();
    ticks(9);
    check("R4", "grn units", int'(grn_count), 'h09);
    check("R5", "red count", int'(red_count), 9);
    check("R8", "yel at top", int'(yel_count), 8);
    check("R8", "yel_run", int'(yel_run), 0);
    ticks(1);
    check("R4", "grn carry", int'(grn_count), 'h10);
    ticks(5);
    check("R6", "grn match", int'(grn_count), 'h15);
    check("R6", "grn_run", int'(grn_run), 0);
    check("R5", "red_run", int'(red_run), 1);
    ticks(3);
    check("R6", "grn hold", int'(grn_count), 'h15);
    check("R5", "red count", int'(red_count), 18);
    ticks(2);
    check("R7", "red match", int'(red_count), 20);
    check("R7", "red_run", int'(red_run), 0);
    ticks(2);
    check("R7", "red hold", int'(red_count), 20);
    check("R8", "yel hold", int'(yel_count), 8);
  endtask

  task automatic t_clear_priority();
    @(negedge clk) red_limit = 7'd50;
    #1 check("R10", "red_run raised", int'(red_run), 1);
    @(negedge clk);
    grn_clr_n = 1'b0; tick = 1'b1;
    @(negedge clk);
    grn_clr_n = 1'b1; tick = 1'b0;
    check("R2", "grn cleared over tick", int'(grn_count), 0);
    check("R10", "red resumed", int'(red_count), 21);
    check("R2", "yel untouched", int'(yel_count), 8);
    repeat (4) @(negedge clk);
    check("R3", "grn no tick", int'(grn_count), 0);
    check("R3", "red no tick", int'(red_count), 21);
  endtask

  task automatic t_yellow();
    clear_all();
    check("R2", "yel cleared", int'(yel_count), 0);
    ticks(7);
    check("R8", "yel 7", int'(yel_count), 7);
    check("R8", "yel_run 7", int'(yel_run), 1);
    ticks(1);
    check("R8", "yel 8", int'(yel_count), 8);
    check("R8", "yel_run 8", int'(yel_run), 0);
    ticks(4);
    check("R8", "yel held", int'(yel_count), 8);
  endtask

  task automatic t_saturate();
    @(negedge clk);
    grn_limit = 8'hAA; red_limit = 7'd120;
    clear_all();
    ticks(99);
    check("R9", "grn 99", int'(grn_count), 'h99);
    check("R9", "red 99", int'(red_count), 99);
    ticks(3);
    check("R9", "grn capped", int'(grn_count), 'h99);
    check("R9", "red capped", int'(red_count), 99);
    check("R9", "runs high", int'({grn_run, red_run}), 3);
  endtask

  task automatic t_restart();
    @(negedge clk);
    grn_limit = 8'h00; red_limit = 7'd3;
    clear_all();
    check("R6", "grn zero setting", int'(grn_run), 0);
    ticks(2);
    check("R6", "grn stays zero", int'(grn_count), 0);
    ticks(2);
    check("R7", "red at 3", int'(red_count), 3);
    check("R7", "red_run", int'(red_run), 0);
    @(negedge clk) grn_limit = 8'h02;
    #1 check("R10", "grn_run raised", int'(grn_run), 1);
    @(negedge clk) red_clr_n = 1'b0;
    @(negedge clk) red_clr_n = 1'b1;
    check("R11", "red restart", int'(red_count), 0);
    check("R11", "red_run", int'(red_run), 1);
    ticks(1);
    check("R11", "red counts", int'(red_count), 1);
    check("R10", "grn resumed", int'(grn_count), 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    t_reset();
    t_green_red_yellow();
    t_clear_priority();
    t_yellow();
    t_saturate();
    t_restart();
    finish_run();
  end
endmodule